// File: doc/BRIEF.md
# UART FIFO and DMA-ready signalling controller

This block sits between the host bus and the serial shifters of one UART channel. It holds a transmit queue and a receive queue of bytes, each 32 entries deep. From their fill levels it produces two active-low DMA request outputs and two level interrupts. An 8-bit control byte written by the host turns the queues on or off, empties either queue, picks one of two DMA signalling schemes, and sets the two fill thresholds. With the queues off, each direction holds a single character.

In the single-transfer scheme the DMA requests follow the empty and non-empty state of the queues. In the block scheme they follow the programmed thresholds with hysteresis. The transmit request stays active until the queue is full. The receive request stays active from the threshold until the queue is empty. The serial transmitter pulls bytes with a load strobe. The serial receiver pushes bytes with a valid strobe, and a byte it pushes into a full queue is lost and recorded in a sticky flag.

Top module: `uart_fifo_dma_ctrl`

## Requirements
- R1: Each queue returns bytes in write order. With control bit 0 set a queue holds up to 32 bytes; with bit 0 clear it holds exactly one.
- R2: A host write to a full transmit queue is discarded. A receive byte arriving at a full receive queue is discarded and sets `overrun_o`, which stays set until the receive queue is emptied by bit 1 or by a change of bit 0.
- R3: Control bit 3 selects the block scheme (1) or the single-transfer scheme (0, the reset value). Bit 3 has no effect while bit 0 is clear.
- R4: In the single-transfer scheme, `txrdy_no` is 0 exactly when the transmit queue is empty. It goes to 1 in the cycle after the first byte is written.
- R5: In the single-transfer scheme, `rxrdy_no` is 0 exactly when the receive queue holds at least one byte.
- R6: Control bits 7:6 set the receive threshold: 00→8, 01→16, 10→24, 11→28. Bits 5:4 set the transmit threshold: 00→16, 01→8, 10→24, 11→30.
- R7: In the block scheme, `txrdy_no` goes to 0 when the transmit count is below the threshold and returns to 1 only when the queue is full. Between those two points it keeps its value.
- R8: In the block scheme, `rxrdy_no` goes to 0 when the receive count reaches the threshold, stays 0 while bytes remain, and returns to 1 when the queue is empty.
- R9: In the block scheme, `tx_irq_o` is 1 while the transmit count is below its threshold and `rx_irq_o` is 1 while the receive count is at or above its threshold. In the single-transfer scheme `tx_irq_o` flags an empty transmit queue and `rx_irq_o` flags a non-empty receive queue.
- R10: Control bits 2 (transmit) and 1 (receive) are self-clearing strobes that empty the queue. A change of bit 0 empties both queues. The queue counts and the ready outputs reflect the empty queue in the cycle after the write.
- R11: After reset, both queues are empty, the queues are off, and the single-transfer scheme is selected: `txrdy_no`=0, `rxrdy_no`=1, `tx_irq_o`=1, `rx_irq_o`=0, `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_we_i | input | 1 | Control byte write strobe |
| fcr_wdata_i | input | 8 | Control byte |
| thr_we_i | input | 1 | Host write strobe to the transmit queue |
| thr_wdata_i | input | 8 | Host transmit byte |
| tx_load_i | input | 1 | Serial transmitter takes the head byte |
| tx_data_o | output | 8 | Head byte of the transmit queue |
| tx_avail_o | output | 1 | Transmit queue not empty |
| rx_valid_i | input | 1 | Serial receiver delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rhr_re_i | input | 1 | Host read strobe from the receive queue |
| rhr_rdata_o | output | 8 | Head byte of the receive queue |
| rx_avail_o | output | 1 | Receive queue not empty |
| txrdy_no | output | 1 | Transmit DMA request, active low |
| rxrdy_no | output | 1 | Receive DMA request, active low |
| tx_irq_o | output | 1 | Transmit threshold interrupt |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
The properties assume that all strobes are single-cycle pulses sampled at the rising edge and that they never carry unknown values after reset. They also assume that a pop strobe on an empty queue changes nothing. The stimulus drives every strobe for exactly one cycle from the falling edge. It issues loads and reads only while the queue holds data, and it reaches the full cases on purpose with extra writes and pushes. Control writes are spaced apart, so each threshold or scheme change is settled before the next fill sequence starts.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 32;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH) + 1;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       blk_mode;
    logic       tx_clr;
    logic       rx_clr;
    logic       q_en;
  } ctrl_t;

  function automatic cnt_t rx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return cnt_t'(8);
      2'b01:   return cnt_t'(16);
      2'b10:   return cnt_t'(24);
      default: return cnt_t'(28);
    endcase
  endfunction

  function automatic cnt_t tx_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return cnt_t'(16);
      2'b01:   return cnt_t'(8);
      2'b10:   return cnt_t'(24);
      default: return cnt_t'(30);
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic [$clog2(DEPTH):0]     limit_i,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  output logic [W-1:0]               rdata_o,
  output logic [$clog2(DEPTH):0]     cnt_o,
  output logic [$clog2(DEPTH):0]     cnt_nxt_o,
  output logic                       drop_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push;

  assign full    = cnt_q >= limit_i;
  assign do_pop  = pop_i & (cnt_q != '0);
  assign do_push = push_i & (~full | do_pop);
  assign drop_o  = push_i & ~do_push & ~flush_i;

  assign cnt_nxt_o = flush_i ? '0 : cnt_q + CW'(do_push) - CW'(do_pop);
  assign cnt_o     = cnt_q;
  assign rdata_o   = mem[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (flush_i) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (do_push) wptr_q <= wptr_q + AW'(1);
        if (do_pop)  rptr_q <= rptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/rdy_ctrl.sv
module rdy_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_d,
  input  logic       blk_d,
  input  logic [1:0] tx_sel_d,
  input  logic [1:0] rx_sel_d,
  input  cnt_t       tx_nxt,
  input  cnt_t       rx_nxt,
  input  logic       blk_q,
  input  logic [1:0] tx_sel_q,
  input  logic [1:0] rx_sel_q,
  input  cnt_t       tx_cnt,
  input  cnt_t       rx_cnt,
  output logic       txrdy_no,
  output logic       rxrdy_no,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  logic tx_act_q, rx_act_q, tx_act_d, rx_act_d;
  logic m1_d;
  cnt_t tx_thr_d, rx_thr_d, tx_thr_q, rx_thr_q;

  assign m1_d     = blk_d & en_d;
  assign tx_thr_d = tx_level(tx_sel_d);
  assign rx_thr_d = rx_level(rx_sel_d);
  assign tx_thr_q = tx_level(tx_sel_q);
  assign rx_thr_q = rx_level(rx_sel_q);

  // block scheme: set/release points differ, hold in between
  always_comb begin
    tx_act_d = tx_act_q;
    rx_act_d = rx_act_q;
    if (m1_d) begin
      if (tx_nxt >= cnt_t'(DEPTH))  tx_act_d = 1'b0;
      else if (tx_nxt < tx_thr_d)   tx_act_d = 1'b1;
      if (rx_nxt >= rx_thr_d)       rx_act_d = 1'b1;
      else if (rx_nxt == '0)        rx_act_d = 1'b0;
    end else begin
      tx_act_d = (tx_nxt == '0);
      rx_act_d = (rx_nxt != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_act_q <= 1'b1;
      rx_act_q <= 1'b0;
    end else begin
      tx_act_q <= tx_act_d;
      rx_act_q <= rx_act_d;
    end
  end

  assign txrdy_no = ~tx_act_q;
  assign rxrdy_no = ~rx_act_q;
  assign tx_irq_o = blk_q ? (tx_cnt < tx_thr_q)  : (tx_cnt == '0);
  assign rx_irq_o = blk_q ? (rx_cnt >= rx_thr_q) : (rx_cnt != '0);
endmodule

// File: rtl/uart_fifo_dma_ctrl.sv
module uart_fifo_dma_ctrl
  import uart_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fcr_we_i,
  input  logic [7:0] fcr_wdata_i,
  input  logic       thr_we_i,
  input  logic [7:0] thr_wdata_i,
  input  logic       tx_load_i,
  output logic [7:0] tx_data_o,
  output logic       tx_avail_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rhr_re_i,
  output logic [7:0] rhr_rdata_o,
  output logic       rx_avail_o,
  output logic       txrdy_no,
  output logic       rxrdy_no,
  output logic       tx_irq_o,
  output logic       rx_irq_o,
  output logic       overrun_o
);
  ctrl_t      wr;
  logic       en_q, blk_q, en_d, blk_d;
  logic [1:0] txs_q, rxs_q, txs_d, rxs_d;
  logic       en_chg, tx_flush, rx_flush;
  logic       tx_drop, rx_drop, overrun_q;
  cnt_t       tx_cnt, rx_cnt, tx_nxt, rx_nxt, limit;

  assign wr     = ctrl_t'(fcr_wdata_i);
  assign en_chg = fcr_we_i & (wr.q_en != en_q);
  assign tx_flush = fcr_we_i & (wr.tx_clr | en_chg);
  assign rx_flush = fcr_we_i & (wr.rx_clr | en_chg);

  assign en_d  = fcr_we_i ? wr.q_en     : en_q;
  assign blk_d = fcr_we_i ? wr.blk_mode : blk_q;
  assign txs_d = fcr_we_i ? wr.tx_sel   : txs_q;
  assign rxs_d = fcr_we_i ? wr.rx_sel   : rxs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      blk_q     <= 1'b0;
      txs_q     <= 2'b00;
      rxs_q     <= 2'b00;
      overrun_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      blk_q <= blk_d;
      txs_q <= txs_d;
      rxs_q <= rxs_d;
      if (rx_flush)     overrun_q <= 1'b0;
      else if (rx_drop) overrun_q <= 1'b1;
    end
  end

  assign limit = en_q ? cnt_t'(FIFO_DEPTH) : cnt_t'(1);

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(tx_flush), .limit_i(limit),
    .push_i(thr_we_i), .wdata_i(thr_wdata_i),
    .pop_i(tx_load_i), .rdata_o(tx_data_o),
    .cnt_o(tx_cnt), .cnt_nxt_o(tx_nxt), .drop_o(tx_drop)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .limit_i(limit),
    .push_i(rx_valid_i), .wdata_i(rx_data_i),
    .pop_i(rhr_re_i), .rdata_o(rhr_rdata_o),
    .cnt_o(rx_cnt), .cnt_nxt_o(rx_nxt), .drop_o(rx_drop)
  );

  rdy_ctrl #(.DEPTH(FIFO_DEPTH)) u_rdy (
    .clk_i, .rst_ni,
    .en_d, .blk_d, .tx_sel_d(txs_d), .rx_sel_d(rxs_d),
    .tx_nxt, .rx_nxt,
    .blk_q(blk_q & en_q), .tx_sel_q(txs_q), .rx_sel_q(rxs_q),
    .tx_cnt, .rx_cnt,
    .txrdy_no, .rxrdy_no, .tx_irq_o, .rx_irq_o
  );

  assign tx_avail_o = (tx_cnt != '0);
  assign rx_avail_o = (rx_cnt != '0);
  assign overrun_o  = overrun_q;
endmodule

// File: rtl/uart_fifo_dma_ctrl_chk.sv
module uart_fifo_dma_ctrl_chk
  import uart_fifo_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_q,
  input logic       blk_q,
  input logic [1:0] txs_q,
  input logic [1:0] rxs_q,
  input cnt_t       tx_cnt,
  input cnt_t       rx_cnt,
  input logic       tx_drop,
  input logic       txrdy_no,
  input logic       rxrdy_no,
  input logic       overrun_o,
  input logic       fcr_we_i,
  input logic [7:0] fcr_wdata_i,
  input logic       rx_valid_i
);
  logic m1;
  cnt_t cap;
  assign m1  = blk_q & en_q;
  assign cap = en_q ? cnt_t'(FIFO_DEPTH) : cnt_t'(1);

  a_r1_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_cnt <= cap);
  a_r1_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) rx_cnt <= cap);
  a_r2_tx_drop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_drop |=> tx_cnt == $past(tx_cnt));
  a_r2_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_valid_i));
  a_r4_tx_empty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && tx_cnt == '0) |-> !txrdy_no);
  a_r4_tx_data_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && tx_cnt != '0) |-> txrdy_no);
  a_r5_rx_data_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && rx_cnt != '0) |-> !rxrdy_no);
  a_r5_rx_empty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m1 && rx_cnt == '0) |-> rxrdy_no);
  a_r7_tx_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && tx_cnt == cnt_t'(FIFO_DEPTH)) |-> txrdy_no);
  a_r7_tx_below_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && tx_cnt < tx_level(txs_q)) |-> !txrdy_no);
  a_r8_rx_trig_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && rx_cnt >= rx_level(rxs_q)) |-> !rxrdy_no);
  a_r8_rx_empty_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1 && rx_cnt == '0) |-> rxrdy_no);
  a_r10_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[1]) |=> (rx_cnt == '0 && rxrdy_no && !overrun_o));
  a_r10_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_we_i && fcr_wdata_i[2]) |=> (tx_cnt == '0));
endmodule

bind uart_fifo_dma_ctrl uart_fifo_dma_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_q(en_q), .blk_q(blk_q),
  .txs_q(txs_q), .rxs_q(rxs_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_drop(tx_drop), .txrdy_no(txrdy_no), .rxrdy_no(rxrdy_no),
  .overrun_o(overrun_o), .fcr_we_i(fcr_we_i), .fcr_wdata_i(fcr_wdata_i),
  .rx_valid_i(rx_valid_i)
);

// File: tb/uart_fifo_dma_ctrl_tb.sv
module uart_fifo_dma_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fcr_we = 1'b0, thr_we = 1'b0, tx_load = 1'b0, rx_valid = 1'b0, rhr_re = 1'b0;
  logic [7:0] fcr_wdata = '0, thr_wdata = '0, rx_data = '0;
  logic [7:0] tx_data, rhr_rdata;
  logic       tx_avail, rx_avail, txrdy_n, rxrdy_n, tx_irq, rx_irq, overrun;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_fifo_dma_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_wdata),
    .thr_we_i(thr_we), .thr_wdata_i(thr_wdata),
    .tx_load_i(tx_load), .tx_data_o(tx_data), .tx_avail_o(tx_avail),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rhr_re_i(rhr_re), .rhr_rdata_o(rhr_rdata), .rx_avail_o(rx_avail),
    .txrdy_no(txrdy_n), .rxrdy_no(rxrdy_n),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .overrun_o(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctrl_wr(input logic [7:0] b);
    @(negedge clk); fcr_we = 1'b1; fcr_wdata = b;
    @(negedge clk); fcr_we = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] b);
    @(negedge clk); thr_we = 1'b1; thr_wdata = b;
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b);
    @(negedge clk); b = tx_data; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    @(negedge clk); b = rhr_rdata; rhr_re = 1'b1;
    @(negedge clk); rhr_re = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 txrdy_no", 32'(txrdy_n), 1'b0);
    check("R11 rxrdy_no", 32'(rxrdy_n), 1'b1);
    check("R11 tx_irq", 32'(tx_irq), 1'b1);
    check("R11 rx_irq", 32'(rx_irq), 1'b0);
    check("R11 overrun", 32'(overrun), 1'b0);
    check("R11 tx_avail", 32'(tx_avail), 1'b0);
  endtask

  task automatic t_holding();
    logic [7:0] b;
    host_wr(8'hA5);
    check("R4 txrdy after write", 32'(txrdy_n), 1'b1);
    host_wr(8'h3C);
    tx_take(b);
    check("R1 holding tx byte", 32'(b), 32'hA5);
    check("R4 txrdy empty", 32'(txrdy_n), 1'b0);
    check("R2 tx second write dropped", 32'(tx_avail), 1'b0);
    rx_put(8'h11);
    check("R5 rxrdy with byte", 32'(rxrdy_n), 1'b0);
    check("R9 rx_irq single", 32'(rx_irq), 1'b1);
    rx_put(8'h22);
    check("R2 overrun set", 32'(overrun), 1'b1);
    host_rd(b);
    check("R1 holding rx byte", 32'(b), 32'h11);
    check("R5 rxrdy empty", 32'(rxrdy_n), 1'b1);
    check("R2 rx second byte dropped", 32'(rx_avail), 1'b0);
  endtask

  task automatic t_mode_ignored();
    logic [7:0] b;
    ctrl_wr(8'h08);
    check("R2 overrun sticky", 32'(overrun), 1'b1);
    host_wr(8'h5A);
    check("R3 txrdy mode ignored", 32'(txrdy_n), 1'b1);
    check("R3 tx_irq mode ignored", 32'(tx_irq), 1'b0);
    host_wr(8'h77);
    tx_take(b);
    check("R3 still one-deep", 32'(b), 32'h5A);
    check("R3 empty after one", 32'(tx_avail), 1'b0);
  endtask

  task automatic t_fifo_mode0();
    logic [7:0] b;
    ctrl_wr(8'h01);
    check("R10 enable change clears overrun", 32'(overrun), 1'b0);
    for (int i = 0; i < 5; i++) host_wr(8'h10 + 8'(i));
    check("R4 txrdy filled", 32'(txrdy_n), 1'b1);
    for (int i = 0; i < 4; i++) begin
      tx_take(b);
      check("R1 tx order", 32'(b), 32'h10 + i);
    end
    check("R4 txrdy one left", 32'(txrdy_n), 1'b1);
    tx_take(b);
    check("R1 tx last", 32'(b), 32'h14);
    check("R4 txrdy drained", 32'(txrdy_n), 1'b0);
    for (int i = 0; i < 3; i++) rx_put(8'h60 + 8'(i));
    check("R5 rxrdy filled", 32'(rxrdy_n), 1'b0);
    for (int i = 0; i < 3; i++) begin
      host_rd(b);
      check("R1 rx order", 32'(b), 32'h60 + i);
    end
    check("R5 rxrdy drained", 32'(rxrdy_n), 1'b1);
  endtask

  task automatic t_tx_block();
    logic [7:0] b;
    ctrl_wr(8'h09);
    check("R7 txrdy empty", 32'(txrdy_n), 1'b0);
    check("R9 tx_irq empty", 32'(tx_irq), 1'b1);
    for (int i = 0; i < 16; i++) host_wr(8'(i));
    check("R7 txrdy held at 16", 32'(txrdy_n), 1'b0);
    check("R6 tx_irq off at 16", 32'(tx_irq), 1'b0);
    for (int i = 16; i < 31; i++) host_wr(8'(i));
    check("R7 txrdy held at 31", 32'(txrdy_n), 1'b0);
    host_wr(8'd31);
    check("R7 txrdy full", 32'(txrdy_n), 1'b1);
    host_wr(8'hEE);
    for (int i = 0; i < 16; i++) tx_take(b);
    check("R7 txrdy held at 16 down", 32'(txrdy_n), 1'b1);
    check("R9 tx_irq at 16", 32'(tx_irq), 1'b0);
    tx_take(b);
    check("R7 txrdy below 16", 32'(txrdy_n), 1'b0);
    check("R9 tx_irq at 15", 32'(tx_irq), 1'b1);
    for (int i = 0; i < 15; i++) tx_take(b);
    check("R2 full write dropped", 32'(b), 32'd31);
    check("R1 tx drained", 32'(tx_avail), 1'b0);
  endtask

  task automatic tx_probe(input logic [7:0] ctl, input int lvl);
    ctrl_wr(ctl);
    for (int i = 0; i < lvl - 1; i++) host_wr(8'(i));
    check("R6 tx_irq below level", 32'(tx_irq), 1'b1);
    host_wr(8'hFF);
    check("R6 tx_irq at level", 32'(tx_irq), 1'b0);
  endtask

  task automatic rx_probe(input logic [7:0] ctl, input int lvl);
    ctrl_wr(ctl);
    for (int i = 0; i < lvl - 1; i++) rx_put(8'(i));
    check("R6 rx_irq below level", 32'(rx_irq), 1'b0);
    check("R8 rxrdy below level", 32'(rxrdy_n), 1'b1);
    rx_put(8'hFF);
    check("R6 rx_irq at level", 32'(rx_irq), 1'b1);
    check("R8 rxrdy at level", 32'(rxrdy_n), 1'b0);
  endtask

  task automatic t_tx_hyst30();
    logic [7:0] b;
    ctrl_wr(8'h3D);
    for (int i = 0; i < 30; i++) host_wr(8'(i));
    check("R9 tx_irq at 30", 32'(tx_irq), 1'b0);
    check("R7 txrdy held at 30", 32'(txrdy_n), 1'b0);
    host_wr(8'd30); host_wr(8'd31);
    check("R7 txrdy full 30", 32'(txrdy_n), 1'b1);
    tx_take(b); tx_take(b);
    check("R7 txrdy held 30 down", 32'(txrdy_n), 1'b1);
    tx_take(b);
    check("R7 txrdy at 29", 32'(txrdy_n), 1'b0);
    check("R9 tx_irq at 29", 32'(tx_irq), 1'b1);
  endtask

  task automatic t_rx_block();
    logic [7:0] b;
    ctrl_wr(8'h4B);
    for (int i = 0; i < 32; i++) rx_put(8'h40 + 8'(i));
    check("R8 rxrdy full", 32'(rxrdy_n), 1'b0);
    check("R2 no overrun at 32", 32'(overrun), 1'b0);
    rx_put(8'hEE);
    check("R2 overrun at 33", 32'(overrun), 1'b1);
    host_rd(b);
    check("R1 rx first", 32'(b), 32'h40);
    for (int i = 1; i < 16; i++) host_rd(b);
    check("R9 rx_irq at 16", 32'(rx_irq), 1'b1);
    host_rd(b);
    check("R8 rxrdy held at 15", 32'(rxrdy_n), 1'b0);
    check("R9 rx_irq at 15", 32'(rx_irq), 1'b0);
    for (int i = 0; i < 14; i++) host_rd(b);
    check("R8 rxrdy held at 1", 32'(rxrdy_n), 1'b0);
    host_rd(b);
    check("R2 rx last kept, extra dropped", 32'(b), 32'h5F);
    check("R8 rxrdy empty", 32'(rxrdy_n), 1'b1);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 33; i++) rx_put(8'(i));
    check("R2 overrun before flush", 32'(overrun), 1'b1);
    ctrl_wr(8'h4B);
    check("R10 rx flushed", 32'(rx_avail), 1'b0);
    check("R10 rxrdy after flush", 32'(rxrdy_n), 1'b1);
    check("R10 overrun after flush", 32'(overrun), 1'b0);
    ctrl_wr(8'h01);
    for (int i = 0; i < 3; i++) host_wr(8'(i));
    check("R10 txrdy before flush", 32'(txrdy_n), 1'b1);
    ctrl_wr(8'h05);
    check("R10 tx flushed", 32'(tx_avail), 1'b0);
    check("R10 txrdy after flush", 32'(txrdy_n), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_holding();
    t_mode_ignored();
    t_fifo_mode0();
    t_tx_block();
    tx_probe(8'h0D, 16);
    tx_probe(8'h1D, 8);
    tx_probe(8'h2D, 24);
    tx_probe(8'h3D, 30);
    t_tx_hyst30();
    rx_probe(8'h0B, 8);
    rx_probe(8'h4B, 16);
    rx_probe(8'h8B, 24);
    rx_probe(8'hCB, 28);
    t_rx_block();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule